// File: doc/BRIEF.md
# Per-Sector ECC Decode Status Collector

A page of flash is read as a run of 512-byte sectors, so a page holds its size divided by 512 sectors, at most eight for a 4 KiB page. After each sector the error-correcting decoder issues a one-cycle report. The report says one of three things about the sector: it was clean, it was repaired with some number of bit corrections, or it could not be repaired. This block gathers those reports for one page. Each sector gets a bit in a mask of uncorrectable sectors and a bit in a mask of repaired sectors. The block also keeps the largest correction count seen in any single sector.

The masks and the count are packed into one status word. A single sticky error flag is set if any sector was repaired or failed. Software clears the flag by writing 1 to it. An enable bit gates the flag onto the interrupt line. The correction strength is chosen with an algorithm bit and a 2-bit selector. A reported count above that strength counts as a failed sector.

A page-start pulse clears the masks and the count. They then hold their values after the last sector until the next start. An all-fail input marks every valid sector as failed at once. Software can then compare the mask with the full sector mask to spot a page that may be erased. The block also shows the number of parity bits that one sector needs at the selected strength.

Top module: `ecc_sector_stat`

## Requirements
- R1: After reset, stat_word is 0, irq_flag is 0 and irq is 0.
- R2: stat_word places the fail mask in bits 31:24, the repaired mask in bits 23:16 and the maximum count in bits 12:8. Bits 15:13 and 7:0 read 0. Bit n of each mask is sector n.
- R3: A report with sec_fail=0 and 0 < sec_bits <= strength sets the sector's repaired bit. The count field becomes the larger of its old value and sec_bits; it never becomes their sum.
- R4: Strength comes from algo_bch and t_sel. With algo_bch=1, t_sel 0,1,2,3 gives 4, 8, 14, 16. With algo_bch=0, t_sel 0,1,2,3 gives 4, 6, 8, 8. A count above the strength sets the fail bit, leaves the repaired bit alone and leaves the count field unchanged.
- R5: A report with sec_fail=1 sets the sector's fail bit, whatever sec_bits holds.
- R6: A report with sec_fail=0 and sec_bits=0 changes neither stat_word nor irq_flag.
- R7: A report whose sec_idx is not below step_count is ignored.
- R8: An all_fail pulse sets fail-mask bits 0 to step_count-1.
- R9: page_start clears both masks and the count field one cycle later. A report or all_fail in the same cycle is ignored. The fields keep their values from then until the next page_start.
- R10: irq_flag sets one cycle after an accepted repaired or failed report, or an accepted all_fail. irq_clr clears it one cycle later. If both happen in the same cycle, the set wins.
- R11: irq is high exactly when irq_flag and irq_en are both high. It follows irq_en in the same cycle.
- R12: parity_bits equals 13 times the strength when algo_bch=1, and 18 times the strength when algo_bch=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Pulse that starts a new page |
| step_count | input | 4 | Number of sectors in the page (1 to 8) |
| algo_bch | input | 1 | 1 selects BCH strengths, 0 selects RS strengths |
| t_sel | input | 2 | Strength selector |
| sec_valid | input | 1 | A sector report is present |
| sec_idx | input | 3 | Index of the reported sector |
| sec_fail | input | 1 | Decoder could not repair the sector |
| sec_bits | input | 5 | Corrections made in the sector |
| all_fail | input | 1 | Mark every valid sector as failed |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1 clear of irq_flag |
| stat_word | output | 32 | Packed masks and maximum count |
| parity_bits | output | 8 | Parity bits per sector |
| irq_flag | output | 1 | Sticky combined error flag |
| irq | output | 1 | Gated interrupt |

## Verification
A report, page_start, all_fail or irq_clr that is present at a clock edge shows up in stat_word and irq_flag right after that edge. Nothing has a later latency. In contrast, irq and parity_bits follow their inputs in the same cycle, with no clock edge in between. The bench changes inputs on the falling edge and advances a reference model at the rising edge. It compares the registered outputs on the next falling edge, and it checks the combinational outputs in the same half-cycle in which it changes their inputs.

// File: rtl/ecc_sector_stat.sv
module ecc_sector_stat #(
  parameter int STEPS  = 8,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = $clog2(STEPS),
  parameter int SCNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_start,
  input  logic [SCNT_W-1:0] step_count,
  input  logic              algo_bch,
  input  logic [1:0]        t_sel,
  input  logic              sec_valid,
  input  logic [IDX_W-1:0]  sec_idx,
  input  logic              sec_fail,
  input  logic [CNT_W-1:0]  sec_bits,
  input  logic              all_fail,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic [31:0]       stat_word,
  output logic [7:0]        parity_bits,
  output logic              irq_flag,
  output logic              irq
);
  logic [STEPS-1:0] fail_m, corr_m, live_m, sec_oh;
  logic [CNT_W-1:0] max_cnt, t_lim;
  logic in_rng, over, take_fail, take_corr, take_all;

  always_comb begin
    if (algo_bch)
      case (t_sel)
        2'd0: t_lim = CNT_W'(4);
        2'd1: t_lim = CNT_W'(8);
        2'd2: t_lim = CNT_W'(14);
        default: t_lim = CNT_W'(16);
      endcase
    else
      case (t_sel)
        2'd0: t_lim = CNT_W'(4);
        2'd1: t_lim = CNT_W'(6);
        default: t_lim = CNT_W'(8);
      endcase
  end

  assign parity_bits = algo_bch ? 8'(t_lim) * 8'd13 : 8'(t_lim) * 8'd18;

  for (genvar i = 0; i < STEPS; i++) begin : g_live
    assign live_m[i] = SCNT_W'(i) < step_count;
  end

  assign sec_oh    = STEPS'(1) << sec_idx;
  assign in_rng    = SCNT_W'(sec_idx) < step_count;
  assign over      = sec_bits > t_lim;
  assign take_fail = sec_valid & in_rng & (sec_fail | over) & ~page_start;
  assign take_corr = sec_valid & in_rng & ~sec_fail & ~over & (sec_bits != '0) & ~page_start;
  assign take_all  = all_fail & (|live_m) & ~page_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_m  <= '0;
      corr_m  <= '0;
      max_cnt <= '0;
    end else if (page_start) begin
      fail_m  <= '0;
      corr_m  <= '0;
      max_cnt <= '0;
    end else begin
      fail_m <= fail_m | (take_fail ? sec_oh : '0) | (take_all ? live_m : '0);
      if (take_corr) begin
        corr_m <= corr_m | sec_oh;
        if (sec_bits > max_cnt) max_cnt <= sec_bits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              irq_flag <= 1'b0;
    else if (take_fail | take_corr | take_all) irq_flag <= 1'b1;
    else if (irq_clr)                        irq_flag <= 1'b0;
  end

  assign irq       = irq_flag & irq_en;
  assign stat_word = {8'(fail_m), 8'(corr_m), 3'b000, 5'(max_cnt), 8'h00};
endmodule

module ecc_sector_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        page_start,
  input logic [3:0]  step_count,
  input logic        sec_valid,
  input logic [2:0]  sec_idx,
  input logic        sec_fail,
  input logic [4:0]  sec_bits,
  input logic        irq_en,
  input logic [31:0] stat_word,
  input logic        irq_flag,
  input logic        irq
);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> (stat_word[31:16] == 16'h0 && stat_word[12:8] == 5'h0));

  p_masks_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |=> ((stat_word[31:16] & $past(stat_word[31:16])) == $past(stat_word[31:16])));

  p_max_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |=> stat_word[12:8] >= $past(stat_word[12:8]));

  p_fail_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_fail && !page_start && ({1'b0, sec_idx} < step_count)) |=> irq_flag);

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && irq_flag));

  p_fail_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_fail && !page_start && ({1'b0, sec_idx} < step_count))
      |=> stat_word[24 + $past(sec_idx)]);
endmodule

bind ecc_sector_stat ecc_sector_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .page_start(page_start), .step_count(step_count),
  .sec_valid(sec_valid), .sec_idx(sec_idx), .sec_fail(sec_fail), .sec_bits(sec_bits),
  .irq_en(irq_en), .stat_word(stat_word), .irq_flag(irq_flag), .irq(irq)
);

// File: tb/ecc_sector_stat_tb.sv
module ecc_sector_stat_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic page_start = 0, algo_bch = 1, sec_valid = 0, sec_fail = 0, all_fail = 0;
  logic irq_en = 0, irq_clr = 0;
  logic [3:0] step_count = 4'd4;
  logic [1:0] t_sel = 2'd0;
  logic [2:0] sec_idx = 3'd0;
  logic [4:0] sec_bits = 5'd0;
  logic [31:0] stat_word;
  logic [7:0] parity_bits;
  logic irq_flag, irq;

  int total = 0, bad = 0;
  logic [7:0] m_fail = 0, m_corr = 0;
  logic [4:0] m_max = 0;
  logic m_flag = 0;

  always #10 clk = ~clk;

  ecc_sector_stat u_dut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .step_count(step_count),
    .algo_bch(algo_bch), .t_sel(t_sel), .sec_valid(sec_valid), .sec_idx(sec_idx),
    .sec_fail(sec_fail), .sec_bits(sec_bits), .all_fail(all_fail), .irq_en(irq_en),
    .irq_clr(irq_clr), .stat_word(stat_word), .parity_bits(parity_bits),
    .irq_flag(irq_flag), .irq(irq)
  );

  function automatic int strength(logic b, logic [1:0] s);
    if (b) return (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 14 : 16;
    return (s == 0) ? 4 : (s == 1) ? 6 : 8;
  endfunction

  function automatic logic [31:0] exp_word();
    return {m_fail, m_corr, 3'b000, m_max, 8'h00};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit inr, ovr, hit;
    inr = {1'b0, sec_idx} < step_count;
    ovr = int'(sec_bits) > strength(algo_bch, t_sel);
    hit = 0;
    if (page_start) begin
      m_fail = 0; m_corr = 0; m_max = 0;
    end else begin
      if (all_fail && step_count != 0) begin
        for (int i = 0; i < 8; i++) if (i < int'(step_count)) m_fail[i] = 1;
        hit = 1;
      end
      if (sec_valid && inr && (sec_fail || ovr)) begin
        m_fail[sec_idx] = 1; hit = 1;
      end else if (sec_valid && inr && sec_bits != 0) begin
        m_corr[sec_idx] = 1; hit = 1;
        if (sec_bits > m_max) m_max = sec_bits;
      end
    end
    if (hit) m_flag = 1;
    else if (irq_clr) m_flag = 0;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " word"}, stat_word, exp_word());
    check({tag, " flag"}, {31'b0, irq_flag}, {31'b0, m_flag});
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag & irq_en});
    page_start = 0; sec_valid = 0; sec_fail = 0; all_fail = 0; irq_clr = 0; sec_bits = 0;
  endtask

  task automatic rep(logic [2:0] idx, logic f, logic [4:0] b);
    sec_valid = 1; sec_idx = idx; sec_fail = f; sec_bits = b;
  endtask

  initial begin
    #5_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check("R1 word", stat_word, 32'h0);
    check("R1 flag", {31'b0, irq_flag}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 4; s++) begin
        algo_bch = a[0]; t_sel = s[1:0]; #1;
        check("R12 parity", {24'b0, parity_bits},
              32'(strength(a[0], s[1:0]) * (a[0] ? 13 : 18)));
      end
    algo_bch = 1; t_sel = 0; step_count = 4;

    page_start = 1; cyc("R9 start");
    rep(1, 0, 3); cyc("R3 corr");
    check("R2 R3 layout", stat_word, 32'h0002_0300);
    rep(2, 0, 2); cyc("R3 max");
    check("R3 not sum", stat_word, 32'h0006_0300);
    irq_clr = 1; cyc("R10 clear");
    check("R10 cleared", {31'b0, irq_flag}, 32'h0);
    rep(0, 0, 0); cyc("R6 clean");
    check("R6 unchanged", stat_word, 32'h0006_0300);
    check("R6 no flag", {31'b0, irq_flag}, 32'h0);
    rep(3, 0, 5); cyc("R4 over");
    check("R4 over strength", stat_word, 32'h0806_0300);
    algo_bch = 0; t_sel = 1;
    rep(2, 0, 6); cyc("R4 rs edge");
    check("R4 at strength", stat_word, 32'h0806_0600);
    rep(3, 0, 7); cyc("R4 rs over");
    check("R4 rs over", stat_word, 32'h0806_0600);
    rep(5, 0, 1); cyc("R7 range");
    check("R7 ignored", stat_word, 32'h0806_0600);
    rep(0, 1, 0); cyc("R5 fail");
    check("R5 fail bit", stat_word, 32'h0906_0600);
    irq_en = 0; #1;
    check("R11 gated off", {31'b0, irq}, 32'h0);
    irq_en = 1; #1;
    check("R11 gated on", {31'b0, irq}, 32'h1);
    irq_clr = 1; rep(1, 1, 0); cyc("R10 set wins");
    check("R10 set wins", {31'b0, irq_flag}, 32'h1);
    page_start = 1; rep(0, 0, 1); cyc("R9 priority");
    check("R9 cleared", stat_word, 32'h0);
    rep(0, 0, 1); cyc("R9 fill");
    cyc("R9 hold");
    check("R9 retained", stat_word, 32'h0001_0100);
    all_fail = 1; cyc("R8 all4");
    check("R8 four", stat_word[31:24], 32'h0F);
    step_count = 8; all_fail = 1; cyc("R8 all8");
    check("R8 eight", stat_word[31:24], 32'hFF);

    for (int k = 0; k < 3000; k++) begin
      page_start = ($urandom % 16) == 0;
      step_count = 4'(1 + ($urandom % 8));
      algo_bch = $urandom % 2;
      t_sel = 2'($urandom % 4);
      sec_valid = ($urandom % 4) != 0;
      sec_idx = 3'($urandom % 8);
      sec_fail = ($urandom % 8) == 0;
      sec_bits = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom % 20);
      all_fail = ($urandom % 40) == 0;
      irq_clr = ($urandom % 5) == 0;
      irq_en = $urandom % 2;
      cyc("R2 R3 R4 R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule